// File: doc/BRIEF.md
# Regulator Target Slew Sequencer

This block owns the digital output-voltage target of a step-down regulator. The target is a 6-bit count in which each unit stands for one 25 mV step. When the block is enabled, it turns on the reference and keeps the power stage quiet until the reference reports that it has cleared its undervoltage lockout. It then latches a final target and raises the count one step per divided timing tick. When it is disabled, it drops power-good at once, lowers the count to zero, parks the gates and turns the reference off.

The final target comes from a two-way selector. One input is a 6-bit code taken directly from the pins. The other is one of four preset codes, chosen by a 2-bit suspend code through a one-hot decoder. The presets sit in registers that reset loads from parameter defaults. Once startup has finished, the count follows any change of the selected target in either direction at the same rate, and power-good stays high while it does.

A timing pulse input stands for the external timing clock. An internal 2-bit prescaler turns every fourth pulse into a step tick. The prescaler restarts from zero on every sequencer state change.

Top module: `vtarget_seq`

## Requirements
- R1: After reset, `vtarget` is 0, `pgood`, `ref_en` and `sw_en` are 0, and `ls_force_on` and `hs_force_off` are 1.
- R2: When `run_en` rises, `ref_en` goes high one cycle later. `sw_en` stays low and `vtarget` stays 0 for as long as `ref_ok` is low.
- R3: `pgood` is low in any cycle in which `run_en` is low, including the very cycle in which it falls.
- R4: `vtarget` changes by exactly one count, and only on the fourth `time_pulse` counted from the latest state change. Later steps follow on every further fourth pulse.
- R5: The up-ramp target is latched once, in the cycle in which `ref_ok` is seen. Changes to the selector inputs during the up-ramp do not move the end point of that ramp.
- R6: With `sus_sel` = 0 the target is `vid_code`, and `sus_code` is ignored. With `sus_sel` = 1 the target is the preset for `sus_code`, with defaults 0→12, 1→20, 2→8 and 3→30.
- R7: `pgood` is high only once the up-ramp has reached its target and the following cycle has begun, and only while `in_reg` is high.
- R8: After startup, a change of the selected target moves `vtarget` toward the new value one count per tick, up or down, and `pgood` stays high throughout.
- R9: On shutdown, `vtarget` falls one count per tick to 0. One cycle after it reaches 0, `ref_en` and `sw_en` go low and `ls_force_on` and `hs_force_off` go high.
- R10: If `run_en` falls during the up-ramp, the up-ramp stops and the down-ramp starts from the current value, with its first decrement on the fourth pulse after the fall.
- R11: Once a down-ramp has started, it runs to 0 and passes through the idle state even if `run_en` returns high. Startup then begins again.
- R12: A final target of 0 finishes startup without any step. `pgood` rises one cycle after the up-ramp state is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Regulator enable |
| time_pulse | input | 1 | One-cycle pulse per timing-clock period |
| ref_ok | input | 1 | Reference has cleared its undervoltage lockout |
| in_reg | input | 1 | Output is within regulation |
| sus_sel | input | 1 | Target select: 0 direct code, 1 suspend preset |
| vid_code | input | 6 | Direct target code |
| sus_code | input | 2 | Suspend preset index |
| vtarget | output | 6 | Current target count (25 mV steps) |
| pgood | output | 1 | Power-good |
| ref_en | output | 1 | Reference enable |
| sw_en | output | 1 | Power stage allowed to switch |
| ls_force_on | output | 1 | Low-side gate held on |
| hs_force_off | output | 1 | High-side gate held off |

## Verification
The selector is exercised with a table of complete startup/shutdown cycles. The table mixes direct codes, including one with a non-zero suspend code that must be ignored, and all four presets, each paired with a direct code that differs from the preset, so a swapped select or a wrong preset shows up as a wrong settled count. Pulse-exact probes check that three pulses leave the count unchanged and the fourth moves it; this separates a correct divide-by-4 prescaler that clears on state change from one that never clears or divides wrongly. Further patterns cover a selector change during the up-ramp (latched versus live target), a rise and a fall after startup with `in_reg` toggled, an abort in mid-ramp, a re-enable during the down-ramp and a zero target, each of which reaches a different end state if the sequencing is wrong.

// File: rtl/vtseq_pkg.sv
`timescale 1ns/1ps
package vtseq_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        SQ_OFF  = 3'd0,   // idle: reference off, gates parked
        SQ_WREF = 3'd1,   // reference on, waiting for lockout release
        SQ_UP   = 3'd2,   // ramping to latched target
        SQ_ON   = 3'd3,   // regulating, tracking target changes
        SQ_DN   = 3'd4    // ramping down to zero
    } seq_state_e;

endpackage

// File: rtl/vts_prescale.sv
`timescale 1ns/1ps
// Divides the timing pulse by 2**DIV_W; cleared on request.
module vts_prescale #(
    parameter int DIV_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic pulse,
    output logic tick
);
    localparam logic [DIV_W-1:0] CNT_LAST = {DIV_W{1'b1}};

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (pulse) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Tick depends only on the stored count, never on the clear.
    assign tick = pulse && (cnt_q == CNT_LAST);

endmodule

// File: rtl/vts_goal_sel.sv
`timescale 1ns/1ps
// Target selector: direct code or decoded suspend preset.
module vts_goal_sel #(
    parameter int                              CODE_W  = 6,
    parameter int                              SEL_W   = 2,
    parameter logic [(2**SEL_W)*CODE_W-1:0]    PRESETS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sus_sel,
    input  logic [SEL_W-1:0]  sus_code,
    input  logic [CODE_W-1:0] vid_code,
    output logic [CODE_W-1:0] goal
);
    localparam int NPRE = 2**SEL_W;

    logic [CODE_W-1:0] pre_d [NPRE];
    logic [CODE_W-1:0] pre_q [NPRE];
    logic [NPRE-1:0]   pre_hot;
    logic [CODE_W-1:0] pre_pick;

    // Preset registers, loaded from defaults on reset
    for (genvar gi = 0; gi < NPRE; gi++) begin : g_pre
        always_comb begin
            pre_d[gi] = pre_q[gi];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pre_q[gi] <= PRESETS[gi*CODE_W +: CODE_W];
            end else begin
                pre_q[gi] <= pre_d[gi];
            end
        end
    end

    // One-hot decode of the suspend code, then AND-OR pick
    always_comb begin
        pre_hot  = '0;
        pre_hot[sus_code] = 1'b1;
        pre_pick = '0;
        for (int k = 0; k < NPRE; k++) begin
            pre_pick = pre_pick | (pre_hot[k] ? pre_q[k] : '0);
        end
    end

    assign goal = sus_sel ? pre_pick : vid_code;

endmodule

// File: rtl/vts_stepper.sv
`timescale 1ns/1ps
// Moves a level one count toward a goal when enabled.
module vts_stepper #(
    parameter int CODE_W = 6
) (
    input  logic [CODE_W-1:0] cur,
    input  logic [CODE_W-1:0] goal,
    input  logic              en,
    output logic [CODE_W-1:0] nxt
);
    always_comb begin
        nxt = cur;
        if (en) begin
            if (cur < goal) begin
                nxt = cur + 1'b1;
            end else if (cur > goal) begin
                nxt = cur - 1'b1;
            end
        end
    end

endmodule

// File: rtl/vtarget_seq.sv
`timescale 1ns/1ps
module vtarget_seq
    import vtseq_pkg::*;
#(
    parameter int                           CODE_W  = 6,
    parameter int                           SEL_W   = 2,
    parameter int                           DIV_W   = 2,
    parameter logic [(2**SEL_W)*CODE_W-1:0] PRESETS = {6'd30, 6'd8, 6'd20, 6'd12}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              time_pulse,
    input  logic              ref_ok,
    input  logic              in_reg,
    input  logic              sus_sel,
    input  logic [SEL_W-1:0]  sus_code,
    input  logic [CODE_W-1:0] vid_code,
    output logic [CODE_W-1:0] vtarget,
    output logic              pgood,
    output logic              ref_en,
    output logic              sw_en,
    output logic              ls_force_on,
    output logic              hs_force_off
);
    localparam logic [CODE_W-1:0] LVL_ZERO = '0;

    typedef struct packed {
        seq_state_e        st;
        logic [CODE_W-1:0] lvl;
        logic [CODE_W-1:0] goal;
    } seq_t;

    seq_t s_d, s_q;

    logic              tick;
    logic              pre_clr;
    logic [CODE_W-1:0] sel_goal;
    logic [CODE_W-1:0] step_goal;
    logic              step_en;
    logic [CODE_W-1:0] step_nxt;

    vts_prescale #(.DIV_W(DIV_W)) i_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pre_clr),
        .pulse (time_pulse),
        .tick  (tick)
    );

    vts_goal_sel #(
        .CODE_W  (CODE_W),
        .SEL_W   (SEL_W),
        .PRESETS (PRESETS)
    ) i_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .sus_sel  (sus_sel),
        .sus_code (sus_code),
        .vid_code (vid_code),
        .goal     (sel_goal)
    );

    vts_stepper #(.CODE_W(CODE_W)) i_step (
        .cur  (s_q.lvl),
        .goal (step_goal),
        .en   (step_en),
        .nxt  (step_nxt)
    );

    // Step control, from registered state only
    always_comb begin
        step_goal = (s_q.st == SQ_DN) ? LVL_ZERO : s_q.goal;
        case (s_q.st)
            SQ_UP, SQ_ON: step_en = tick && run_en;
            SQ_DN:        step_en = tick;
            default:      step_en = 1'b0;
        endcase
    end

    // Next-state computation
    always_comb begin
        s_d     = s_q;
        s_d.lvl = step_nxt;
        case (s_q.st)
            SQ_OFF: begin
                s_d.lvl = LVL_ZERO;
                if (run_en) begin
                    s_d.st = SQ_WREF;
                end
            end
            SQ_WREF: begin
                if (!run_en) begin
                    s_d.st = SQ_OFF;
                end else if (ref_ok) begin
                    s_d.st   = SQ_UP;
                    s_d.goal = sel_goal;
                end
            end
            SQ_UP: begin
                if (!run_en) begin
                    s_d.st = SQ_DN;
                end else if (s_q.lvl == s_q.goal) begin
                    s_d.st = SQ_ON;
                end
            end
            SQ_ON: begin
                s_d.goal = sel_goal;
                if (!run_en) begin
                    s_d.st = SQ_DN;
                end
            end
            SQ_DN: begin
                if (s_q.lvl == LVL_ZERO) begin
                    s_d.st = SQ_OFF;
                end
            end
            default: begin
                s_d.st  = SQ_OFF;
                s_d.lvl = LVL_ZERO;
            end
        endcase
    end

    assign pre_clr = (s_d.st != s_q.st);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= SQ_OFF;
            s_q.lvl  <= LVL_ZERO;
            s_q.goal <= LVL_ZERO;
        end else begin
            s_q <= s_d;
        end
    end

    // Output decode
    assign vtarget      = s_q.lvl;
    assign pgood        = (s_q.st == SQ_ON) && in_reg && run_en;
    assign ref_en       = (s_q.st != SQ_OFF);
    assign sw_en        = (s_q.st == SQ_UP) || (s_q.st == SQ_ON) || (s_q.st == SQ_DN);
    assign ls_force_on  = !sw_en;
    assign hs_force_off = !sw_en;

endmodule

// File: rtl/vts_checker.sv
`timescale 1ns/1ps
module vts_checker #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic              time_pulse,
    input logic              ref_ok,
    input logic              in_reg,
    input logic [CODE_W-1:0] vtarget,
    input logic              pgood,
    input logic              ref_en,
    input logic              sw_en,
    input logic              ls_force_on,
    input logic              hs_force_off
);
    logic [CODE_W:0] lvl_ext;
    assign lvl_ext = {1'b0, vtarget};

    // R3: power-good low whenever enable is low
    p_pgood_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !pgood);

    // R4: level moves by exactly one count
    p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_ext != $past(lvl_ext)) |->
            ((lvl_ext == $past(lvl_ext) + 1'b1) || ($past(lvl_ext) == lvl_ext + 1'b1)));

    // R4: level moves only after a timing pulse
    p_step_on_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_ext != $past(lvl_ext)) |-> $past(time_pulse));

    // R2: switching starts only with the reference on and ready
    p_ref_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_en) |-> ($past(ref_ok) && $past(ref_en)));

    // R9: idle means gates parked and level at zero
    p_idle_parked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_en |-> (ls_force_on && hs_force_off && !sw_en && (vtarget == '0)));

    // R7: power-good requires regulation and an active stage
    p_pgood_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pgood |-> (in_reg && sw_en && ref_en));

endmodule

bind vtarget_seq vts_checker #(.CODE_W(CODE_W)) i_vts_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_en       (run_en),
    .time_pulse   (time_pulse),
    .ref_ok       (ref_ok),
    .in_reg       (in_reg),
    .vtarget      (vtarget),
    .pgood        (pgood),
    .ref_en       (ref_en),
    .sw_en        (sw_en),
    .ls_force_on  (ls_force_on),
    .hs_force_off (hs_force_off)
);

// File: tb/test_vtarget_seq.sv
`timescale 1ns/1ps
module test_vtarget_seq;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       run_en, time_pulse, ref_ok, in_reg, sus_sel;
    logic [1:0] sus_code;
    logic [5:0] vid_code;
    logic [5:0] vtarget;
    logic       pgood, ref_en, sw_en, ls_force_on, hs_force_off;

    int checks = 0;
    int errors = 0;

    // {sus_sel, sus_code, vid_code, expected target}
    localparam int NVEC = 6;
    localparam logic [14:0] VECS [NVEC] = '{
        {1'b0, 2'd0, 6'd17, 6'd17},
        {1'b0, 2'd3, 6'd45, 6'd45},
        {1'b1, 2'd0, 6'd40, 6'd12},
        {1'b1, 2'd1, 6'd40, 6'd20},
        {1'b1, 2'd2, 6'd3,  6'd8},
        {1'b1, 2'd3, 6'd0,  6'd30}
    };

    always #2.5 clk = ~clk;

    vtarget_seq i_vtarget_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_en       (run_en),
        .time_pulse   (time_pulse),
        .ref_ok       (ref_ok),
        .in_reg       (in_reg),
        .sus_sel      (sus_sel),
        .sus_code     (sus_code),
        .vid_code     (vid_code),
        .vtarget      (vtarget),
        .pgood        (pgood),
        .ref_en       (ref_en),
        .sw_en        (sw_en),
        .ls_force_on  (ls_force_on),
        .hs_force_off (hs_force_off)
    );

    task automatic chk(input int act, input int exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) time_pulse = 1'b1;
            @(negedge clk) time_pulse = 1'b0;
        end
    endtask

    // Enable; returns after the up-ramp state is entered (ref_ok high)
    task automatic start_up();
        @(negedge clk) run_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Disable; returns after the down-ramp state is entered
    task automatic begin_down();
        @(negedge clk) run_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; run_en = 1'b0; time_pulse = 1'b0; ref_ok = 1'b0;
        in_reg = 1'b1; sus_sel = 1'b0; sus_code = 2'd0; vid_code = 6'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(vtarget, 0, "R1 vtarget");
        chk({pgood, ref_en, sw_en}, 0, "R1 pgood/ref_en/sw_en");
        chk({ls_force_on, hs_force_off}, 3, "R1 gate forces");

        // R2 reference first, no switching before ready
        vid_code = 6'd6;
        @(negedge clk) run_en = 1'b1;
        @(negedge clk);
        chk(ref_en, 1, "R2 ref_en after enable");
        chk(sw_en, 0, "R2 sw_en before ref_ok");
        pulses(8);
        chk(vtarget, 0, "R2 vtarget held while ref_ok low");
        chk(sw_en, 0, "R2 sw_en held while ref_ok low");
        @(negedge clk) ref_ok = 1'b1;
        @(negedge clk);
        chk(sw_en, 1, "R2 sw_en after ref_ok");
        chk(ls_force_on, 0, "R2 low-side released");

        // R4 divide-by-4 from state change
        pulses(3);
        chk(vtarget, 0, "R4 no step after 3 pulses");
        pulses(1);
        chk(vtarget, 1, "R4 step on 4th pulse");

        // R5 latched target ignores change during ramp
        vid_code = 6'd9;
        pulses(20);
        chk(vtarget, 6, "R5 ramp end at latched target");
        chk(pgood, 0, "R7 pgood low as ramp completes");
        @(negedge clk);
        chk(pgood, 1, "R7 pgood high in regulation");
        chk(vtarget, 6, "R5 regulated at latched target");

        // R8 tracking after startup
        pulses(3);
        chk(vtarget, 6, "R4 first track step waits 4 pulses");
        pulses(1);
        chk(vtarget, 7, "R8 track up step");
        pulses(8);
        chk(vtarget, 9, "R8 track up end");
        pulses(4);
        chk(vtarget, 9, "R8 hold at goal");
        vid_code = 6'd7;
        pulses(4);
        chk(vtarget, 8, "R8 track down step");
        chk(pgood, 1, "R8 pgood during slew");
        in_reg = 1'b0;
        #1 chk(pgood, 0, "R7 pgood needs in_reg");
        in_reg = 1'b1;
        pulses(4);
        chk(vtarget, 7, "R8 track down end");

        // R3 / R9 shutdown
        @(negedge clk) run_en = 1'b0;
        #1 chk(pgood, 0, "R3 pgood drops same cycle");
        @(negedge clk);
        chk(ref_en, 1, "R9 ref_en during down-ramp");
        pulses(3);
        chk(vtarget, 7, "R9 no step after 3 pulses");
        pulses(1);
        chk(vtarget, 6, "R9 down step");
        pulses(24);
        chk(vtarget, 0, "R9 reached zero");
        chk(ref_en, 1, "R9 ref_en still on at zero");
        @(negedge clk);
        chk(ref_en, 0, "R9 ref_en off after zero");
        chk({sw_en, ls_force_on, hs_force_off}, 3, "R9 gates parked");

        // R10 abort during up-ramp
        vid_code = 6'd10;
        start_up();
        pulses(12);
        chk(vtarget, 3, "R10 mid-ramp level");
        begin_down();
        pulses(3);
        chk(vtarget, 3, "R10 held for 3 pulses");
        pulses(1);
        chk(vtarget, 2, "R10 down from current level");
        pulses(8);
        @(negedge clk);
        chk(ref_en, 0, "R10 idle after abort");

        // R11 re-enable during down-ramp
        vid_code = 6'd2;
        start_up();
        pulses(8);
        @(negedge clk);
        chk(pgood, 1, "R11 up at 2");
        begin_down();
        @(negedge clk) run_en = 1'b1;
        pulses(4);
        chk(vtarget, 1, "R11 down-ramp continues");
        pulses(4);
        chk(vtarget, 0, "R11 down-ramp reaches zero");
        @(negedge clk);
        chk(ref_en, 0, "R11 passes through idle");
        @(negedge clk);
        @(negedge clk);
        pulses(8);
        @(negedge clk);
        chk(vtarget, 2, "R11 restart level");
        chk(pgood, 1, "R11 restart pgood");
        begin_down();
        pulses(8);
        @(negedge clk);

        // R12 zero target
        vid_code = 6'd0;
        start_up();
        @(negedge clk);
        chk(pgood, 1, "R12 pgood without steps");
        chk(vtarget, 0, "R12 level zero");
        begin_down();
        @(negedge clk);
        chk(ref_en, 0, "R12 idle after zero shutdown");

        // R6 selector table
        for (int v = 0; v < NVEC; v++) begin
            sus_sel  = VECS[v][14];
            sus_code = VECS[v][13:12];
            vid_code = VECS[v][11:6];
            start_up();
            pulses(4 * int'(VECS[v][5:0]));
            @(negedge clk);
            chk(vtarget, int'(VECS[v][5:0]), "R6 selected target");
            chk(pgood, 1, "R6 pgood at target");
            begin_down();
            pulses(4 * int'(VECS[v][5:0]));
            @(negedge clk);
            chk(ref_en, 0, "R9 idle after table shutdown");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule